// File: doc/BRIEF.md
# Buffered PWM Channel with Output Disable

This block is one timer channel that drives a single pin with a waveform whose period and duty can both be changed while it runs. An internal period counter steps once per prescaler tick. It is compared against two active match values. The duty value moves the pin to the idle level, which is the level given by the polarity input. The period value moves the pin to the opposite level, restarts the counter at 1 and raises a sticky flag.

Software never writes the active values directly. It writes a duty shadow and a period shadow. Both shadows are copied into the active values together, and only on a period match, so a period that is already running keeps its timing.

Two software strobes set the pin the way a match would, without raising the flag. An output-disable input, gated by an enable bit, forces the pin to the idle level on the next clock. After the disable is removed, the pin stays at the idle level until the next match.

Top module: `pwm_shadow_channel`

## Requirements
- R1: The period counter advances by one only on clock cycles where `tick_i` is high. On cycles without a tick, and without a force-period strobe, the counter, pin and flag hold their values.
- R2: A period match (tick high and counter equal to the active period value) has these effects at the next clock edge:
  - the counter reloads to 1;
  - the pin goes to the level opposite `pol_i`;
  - `flag_o` is set.
- R3: A duty match (tick high and counter equal to the active duty value) sets the pin to the `pol_i` level. It sets `flag_o` only while `flag_on_a_i` is 1.
- R4: When both matches occur on the same tick, the period match decides the pin level. With a duty value greater than or equal to the period value, the pin stays at the level opposite `pol_i` for the whole period.
- R5: Writes go only to the shadows:
  - `wr_a_i` loads `wr_data_i` into the duty shadow;
  - `wr_b_i` loads `wr_data_i` into the period shadow;
  - both shadows are copied to the active values only on a period match;
  - a write in the same cycle as a match is carried by the following match.
- R6: While `odis_en_i` and `odis_i` are both 1, the pin is at the `pol_i` level from the next clock edge onward. Matches still move the counter, the active values and the flag during that time.
- R7: After the output disable is removed, the pin keeps the `pol_i` level until the next duty or period match.
- R8: The force strobes act with or without a tick:
  - `force_a_i` sets the pin to the `pol_i` level;
  - `force_b_i` sets the pin to the opposite level and loads the counter with 1;
  - neither strobe sets `flag_o`.

  Priority order: output disable, then force-period, then force-duty, then period match, then duty match.
- R9: `flag_o` stays set until a cycle with `flag_clr_i` high clears it. A set event in the same cycle as a clear wins.
- R10: While reset is held and afterwards until the first event, `pin_o` and `flag_o` are 0. Reset also sets the counter to 1, both duty values to 0 and both period values to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Prescaler tick; counter and comparisons advance only when high |
| wr_a_i | input | 1 | Write strobe for the duty shadow |
| wr_b_i | input | 1 | Write strobe for the period shadow |
| wr_data_i | input | W | Data for a shadow write |
| force_a_i | input | 1 | Force the pin to the duty-match level |
| force_b_i | input | 1 | Force the pin to the period-match level and restart the counter |
| odis_en_i | input | 1 | Enable for the output-disable input |
| odis_i | input | 1 | Output-disable request |
| pol_i | input | 1 | Idle (duty-match) pin level |
| flag_on_a_i | input | 1 | Also raise the flag on duty matches |
| flag_clr_i | input | 1 | Clear the sticky flag |
| pin_o | output | 1 | Channel output pin |
| flag_o | output | 1 | Sticky match flag |

## Verification
Several functions can land in the same cycle:
- the duty and period matches can fall on the same tick;
- a force strobe or the output disable can coincide with a match;
- a flag clear can coincide with a flag-setting match.

The bench provokes the first case with equal duty and period values, and with a duty value above the period value. It provokes the others by holding the clear, the disable or the strobes high across runs of ticks. A behavioural model that applies the stated priority order judges the pin and the flag on every clock.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

  // Level the output stage is asked to take in a cycle
  typedef enum logic [1:0] {
    LVL_KEEP  = 2'd0,
    LVL_IDLE  = 2'd1,   // pin equals polarity input
    LVL_DRIVE = 2'd2    // pin equals inverted polarity input
  } pin_lvl_e;

  localparam int unsigned SEL_DUTY   = 0;
  localparam int unsigned SEL_PERIOD = 1;
  localparam int unsigned NUM_CMP    = 2;

endpackage

// File: rtl/pwmc_match_pair.sv
module pwmc_match_pair #(
  parameter int unsigned W       = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         load_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o
);

  localparam logic [W-1:0] RST_WORD = W'(RST_VAL);

  logic [W-1:0] shadow_q, shadow_d;
  logic [W-1:0] active_q, active_d;
  logic         shadow_en, active_en;

  always_comb begin
    shadow_en = wr_i;
    shadow_d  = wr_data_i;
    active_en = load_i;
    active_d  = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RST_WORD;
      active_q <= RST_WORD;
    end else begin
      if (shadow_en) shadow_q <= shadow_d;
      if (active_en) active_q <= active_d;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;

endmodule

// File: rtl/pwmc_timebase.sv
module pwmc_timebase #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         restart_i,
  input  logic [W-1:0] duty_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         duty_hit_o,
  output logic         period_hit_o
);

  localparam logic [W-1:0] CNT_START = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;
  logic         duty_hit, period_hit;

  always_comb begin
    duty_hit   = tick_i && (cnt_q == duty_i);
    period_hit = tick_i && (cnt_q == period_i);
    cnt_en     = tick_i || restart_i;
    if (restart_i || period_hit) cnt_d = CNT_START;
    else                         cnt_d = cnt_q + CNT_START;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_START;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o        = cnt_q;
  assign duty_hit_o   = duty_hit;
  assign period_hit_o = period_hit;

endmodule

// File: rtl/pwmc_outstage.sv
module pwmc_outstage
  import pwmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pol_i,
  input  logic disable_i,
  input  logic force_duty_i,
  input  logic force_period_i,
  input  logic duty_hit_i,
  input  logic period_hit_i,
  input  logic flag_on_duty_i,
  input  logic flag_clr_i,
  output logic pin_o,
  output logic flag_o
);

  pin_lvl_e lvl_sel;
  logic     pin_q, pin_d, pin_en;
  logic     flag_q, flag_d, flag_en;
  logic     flag_set;

  // Priority: disable > force period > force duty > period match > duty match
  always_comb begin
    if (disable_i)           lvl_sel = LVL_IDLE;
    else if (force_period_i) lvl_sel = LVL_DRIVE;
    else if (force_duty_i)   lvl_sel = LVL_IDLE;
    else if (period_hit_i)   lvl_sel = LVL_DRIVE;
    else if (duty_hit_i)     lvl_sel = LVL_IDLE;
    else                     lvl_sel = LVL_KEEP;
  end

  always_comb begin
    pin_en = (lvl_sel != LVL_KEEP);
    case (lvl_sel)
      LVL_IDLE:  pin_d = pol_i;
      LVL_DRIVE: pin_d = ~pol_i;
      default:   pin_d = pin_q;
    endcase
  end

  always_comb begin
    flag_set = period_hit_i || (duty_hit_i && flag_on_duty_i);
    flag_en  = flag_set || flag_clr_i;
    flag_d   = flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (pin_en)  pin_q  <= pin_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign pin_o  = pin_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/pwm_shadow_channel.sv
module pwm_shadow_channel
  import pwmc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_a_i,
  input  logic         wr_b_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         force_a_i,
  input  logic         force_b_i,
  input  logic         odis_en_i,
  input  logic         odis_i,
  input  logic         pol_i,
  input  logic         flag_on_a_i,
  input  logic         flag_clr_i,
  output logic         pin_o,
  output logic         flag_o
);

  // Reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic         rst_int_n;
  logic [NUM_CMP-1:0] wr_vec;
  logic [W-1:0] shadow_q [NUM_CMP];
  logic [W-1:0] active_q [NUM_CMP];
  logic [W-1:0] cnt;
  logic         a_hit, b_hit;
  logic         disable_act;

  assign rst_int_n   = rst_s2;
  assign wr_vec      = {wr_b_i, wr_a_i};
  assign disable_act = odis_en_i && odis_i;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    localparam int unsigned RV = (g == SEL_PERIOD) ? 1 : 0;
    pwmc_match_pair #(.W(W), .RST_VAL(RV)) u_pair (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr_i      (wr_vec[g]),
      .wr_data_i (wr_data_i),
      .load_i    (b_hit),
      .shadow_o  (shadow_q[g]),
      .active_o  (active_q[g])
    );
  end

  logic [W-1:0] a_shadow, b_shadow, a_active, b_active;
  assign a_shadow = shadow_q[SEL_DUTY];
  assign b_shadow = shadow_q[SEL_PERIOD];
  assign a_active = active_q[SEL_DUTY];
  assign b_active = active_q[SEL_PERIOD];

  pwmc_timebase #(.W(W)) u_tb (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .tick_i       (tick_i),
    .restart_i    (force_b_i),
    .duty_i       (a_active),
    .period_i     (b_active),
    .cnt_o        (cnt),
    .duty_hit_o   (a_hit),
    .period_hit_o (b_hit)
  );

  pwmc_outstage u_out (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .pol_i          (pol_i),
    .disable_i      (disable_act),
    .force_duty_i   (force_a_i),
    .force_period_i (force_b_i),
    .duty_hit_i     (a_hit),
    .period_hit_i   (b_hit),
    .flag_on_duty_i (flag_on_a_i),
    .flag_clr_i     (flag_clr_i),
    .pin_o          (pin_o),
    .flag_o         (flag_o)
  );

endmodule

// File: rtl/pwm_shadow_channel_chk.sv
module pwm_shadow_channel_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         tick_i,
  input logic         force_a_i,
  input logic         force_b_i,
  input logic         odis_en_i,
  input logic         odis_i,
  input logic         pol_i,
  input logic         flag_clr_i,
  input logic         pin_o,
  input logic         flag_o,
  input logic         a_hit,
  input logic         b_hit,
  input logic [W-1:0] cnt,
  input logic [W-1:0] a_shadow,
  input logic [W-1:0] b_shadow,
  input logic [W-1:0] a_active,
  input logic [W-1:0] b_active
);

  a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_ok)
    (!tick_i && !force_b_i) |=> $stable(cnt));

  a_r2_reload_one: assert property (@(posedge clk) disable iff (!rst_ok)
    b_hit |=> (cnt == W'(1)));

  a_r2_flag_on_period: assert property (@(posedge clk) disable iff (!rst_ok)
    b_hit |=> flag_o);

  a_r4_period_wins: assert property (@(posedge clk) disable iff (!rst_ok)
    (a_hit && b_hit && !(odis_en_i && odis_i) && !force_a_i && !force_b_i)
      |=> (pin_o == !$past(pol_i)));

  a_r5_transfer_on_period: assert property (@(posedge clk) disable iff (!rst_ok)
    b_hit |=> (a_active == $past(a_shadow) && b_active == $past(b_shadow)));

  a_r6_disable_idle: assert property (@(posedge clk) disable iff (!rst_ok)
    (odis_en_i && odis_i) |=> (pin_o == $past(pol_i)));

  a_r8_force_no_flag: assert property (@(posedge clk) disable iff (!rst_ok)
    (!flag_o && !a_hit && !b_hit && (force_a_i || force_b_i)) |=> !flag_o);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_ok)
    (flag_o && !flag_clr_i) |=> flag_o);

endmodule

bind pwm_shadow_channel pwm_shadow_channel_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_int_n),
  .tick_i     (tick_i),
  .force_a_i  (force_a_i),
  .force_b_i  (force_b_i),
  .odis_en_i  (odis_en_i),
  .odis_i     (odis_i),
  .pol_i      (pol_i),
  .flag_clr_i (flag_clr_i),
  .pin_o      (pin_o),
  .flag_o     (flag_o),
  .a_hit      (a_hit),
  .b_hit      (b_hit),
  .cnt        (cnt),
  .a_shadow   (a_shadow),
  .b_shadow   (b_shadow),
  .a_active   (a_active),
  .b_active   (b_active)
);

// File: tb/sim_pwm_shadow_channel.sv
`timescale 1ns/1ps
module sim_pwm_shadow_channel;

  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst_n, tick_i, wr_a_i, wr_b_i, force_a_i, force_b_i;
  logic         odis_en_i, odis_i, pol_i, flag_on_a_i, flag_clr_i;
  logic [W-1:0] wr_data_i;
  logic         pin_o, flag_o;

  always #5 clk = ~clk;

  pwm_shadow_channel #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_a_i(wr_a_i), .wr_b_i(wr_b_i),
    .wr_data_i(wr_data_i), .force_a_i(force_a_i), .force_b_i(force_b_i),
    .odis_en_i(odis_en_i), .odis_i(odis_i), .pol_i(pol_i),
    .flag_on_a_i(flag_on_a_i), .flag_clr_i(flag_clr_i),
    .pin_o(pin_o), .flag_o(flag_o)
  );

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R10";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  // Behavioural reference model
  logic [W-1:0] m_cnt, m_a1, m_a2, m_b1, m_b2;
  logic         m_pin, m_flag, m_ah, m_bh;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 1; m_a1 = 0; m_a2 = 0; m_b1 = 1; m_b2 = 1;
      m_pin = 0; m_flag = 0;
    end else begin
      m_ah = tick_i && (m_cnt == m_a1);
      m_bh = tick_i && (m_cnt == m_b1);
      if (odis_en_i && odis_i) m_pin = pol_i;
      else if (force_b_i)      m_pin = ~pol_i;
      else if (force_a_i)      m_pin = pol_i;
      else if (m_bh)           m_pin = ~pol_i;
      else if (m_ah)           m_pin = pol_i;
      if (force_b_i || m_bh) m_cnt = 1;
      else if (tick_i)       m_cnt = m_cnt + 1'b1;
      if (m_bh || (m_ah && flag_on_a_i)) m_flag = 1;
      else if (flag_clr_i)               m_flag = 0;
      if (m_bh) begin m_a1 = m_a2; m_b1 = m_b2; end
      if (wr_a_i) m_a2 = wr_data_i;
      if (wr_b_i) m_b2 = wr_data_i;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(cur_req, "pin_o", pin_o, m_pin);
      check(cur_req, "flag_o", flag_o, m_flag);
    end
  end

  task automatic run(input int n, input int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = ((i % every) == 0);
    end
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic write_regs(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    wr_a_i = 1'b1; wr_data_i = a;
    @(negedge clk);
    wr_a_i = 1'b0; wr_b_i = 1'b1; wr_data_i = b;
    @(negedge clk);
    wr_b_i = 1'b0;
  endtask

  task automatic clear_flag;
    @(negedge clk);
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 0; tick_i = 0; wr_a_i = 0; wr_b_i = 0; wr_data_i = '0;
    force_a_i = 0; force_b_i = 0; odis_en_i = 0; odis_i = 0;
    pol_i = 0; flag_on_a_i = 0; flag_clr_i = 0;
    repeat (3) @(negedge clk);
    cmp_on = 1'b1;
    check("R10", "reset pin", pin_o, 1'b0);
    check("R10", "reset flag", flag_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "idle pin after release", pin_o, 1'b0);

    // R2: reset period of 1 gives a period match on every tick
    cur_req = "R2";
    run(4, 1);
    check("R2", "flag after period match", flag_o, 1'b1);
    check("R2", "pin after period match", pin_o, 1'b1);

    cur_req = "R9";
    clear_flag();
    check("R9", "flag cleared", flag_o, 1'b0);

    // R5: new shadows reach the active values only at the next period match
    cur_req = "R5";
    write_regs(16'd3, 16'd8);
    check("R5", "no change without tick", pin_o, 1'b1);
    run(1, 1);
    cur_req = "R3";
    run(30, 1);
    flag_on_a_i = 1'b1;
    clear_flag();
    run(20, 1);
    flag_on_a_i = 1'b0;

    cur_req = "R1";
    run(45, 3);

    // R4: same-tick matches and duty >= period
    cur_req = "R4";
    write_regs(16'd8, 16'd8);
    run(30, 1);
    write_regs(16'd12, 16'd6);
    run(30, 1);
    check("R4", "constant drive level", pin_o, 1'b1);

    cur_req = "R5";
    write_regs(16'd3, 16'd10);
    run(25, 1);

    // R6/R7: output disable and release
    cur_req = "R6";
    odis_en_i = 1'b1;
    run(5, 1);
    odis_i = 1'b1;
    @(negedge clk);
    check("R6", "pin idle one clock after disable", pin_o, 1'b0);
    run(25, 1);
    cur_req = "R7";
    odis_i = 1'b0;
    @(negedge clk);
    check("R7", "pin held idle after release", pin_o, 1'b0);
    run(25, 1);
    odis_en_i = 1'b0;

    // R8: forces without ticks, then mixed with matches
    cur_req = "R8";
    clear_flag();
    @(negedge clk); force_b_i = 1'b1;
    @(negedge clk); force_b_i = 1'b0;
    check("R8", "force period level", pin_o, 1'b1);
    force_a_i = 1'b1;
    @(negedge clk); force_a_i = 1'b0;
    check("R8", "force duty level", pin_o, 1'b0);
    check("R8", "force leaves flag clear", flag_o, 1'b0);
    for (int k = 0; k < 6; k++) begin
      run(k + 2, 1);
      @(negedge clk); force_a_i = 1'b1; tick_i = 1'b1;
      @(negedge clk); force_a_i = 1'b0; force_b_i = 1'b1;
      @(negedge clk); force_b_i = 1'b0; tick_i = 1'b0;
    end

    // R9: clear held while set events arrive
    cur_req = "R9";
    flag_clr_i = 1'b1;
    run(25, 1);
    flag_clr_i = 1'b0;
    run(5, 1);

    // R3 with inverted polarity
    cur_req = "R3";
    pol_i = 1'b1;
    run(30, 1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
  end

endmodule